// File: doc/BRIEF.md
# RGMII Transmit Clock Generator

This block produces the RGMII transmit clock from one of two parent clocks, set up through a 32-bit control register. The chain has four stages. A source select comes first. A programmable divider follows; its field value N divides by N, and a value of zero acts as one. A fixed halving stage comes next, then a gate. The gate's output is then slowed by the current link speed. At gigabit speed the clock runs at the full rate (nominally 125 MHz when the divided parent is 250 MHz). At 100 Mbit/s it runs five times slower, and at 10 Mbit/s fifty times slower. Software never has to touch the register when the speed changes.

Everything runs on one base clock. Each parent clock appears as a one-cycle tick strobe in that domain, one strobe per parent cycle. Every division is made by counting ticks, and a single toggle flop drives the output. Each half period of the output lasts exactly N × S parent ticks, where S is the speed factor, so the duty cycle is always 50%. New divider, source, speed and gate settings are latched only at the falling edge of the output, or while the output is stopped. Because of this, no runt pulses appear. A 2-bit transmit-delay field is held in the register and passed out to an external delay line.

Top module: `txclk_gen`

## Requirements
- R1: Control bit 4 selects the parent: 0 uses `srcTick0`, 1 uses `srcTick1`.
- R2: Control bits 9:7 hold N. Each output half period lasts N × S parent ticks, so one full output period is 2N × S parent cycles.
- R3: A divider field of 0 behaves exactly like a field of 1.
- R4: Control bit 10 enables the output. When it is 0, the output finishes its current high phase, then goes low and stays low.
- R5: Control bits 6:5 appear on `txDelay` in the cycle after the write.
- R6: `linkSpeed` sets S. 2'b10 and 2'b11 give S=1, 2'b01 gives S=5, and 2'b00 gives S=50. High and low phases are always equal in length.
- R7: Changes to the source, divider, speed or gate take effect only after the current period ends with a falling edge. A high phase in progress always completes at its old length.
- R8: `rdData` returns the written bits 10:4 and zero in every other bit.
- R9: A synchronous active-high `rst` clears the register. After reset, `rdData` and `txDelay` are zero and `txClk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data |
| srcTick0 | input | 1 | Tick strobe for parent clock 0, one per parent cycle |
| srcTick1 | input | 1 | Tick strobe for parent clock 1, one per parent cycle |
| linkSpeed | input | 2 | Link speed: 00 = 10M, 01 = 100M, 10/11 = 1G |
| txDelay | output | 2 | Transmit delay setting for the external delay line |
| txClk | output | 1 | Generated transmit clock |

## Verification
The bench uses the default parameters: a 3-bit divider field and speed factors of 5 and 50. With these, half periods range from 1 to 350 ticks. The bench ticks parent 0 every base cycle and parent 1 every third cycle. Each measured phase length is therefore the product of divider, speed factor and source rate, so every stage of the chain is visible in one number. Directed runs change the settings in the middle of a long high phase, including closing the gate. These runs show that the phase in progress still finishes at its old length.

// File: rtl/txclk_pkg.sv
package txclk_pkg;
  parameter int DIV_W    = 3;
  parameter int MID_MUL  = 5;
  parameter int LOW_MUL  = 50;
  parameter int SEL_BIT  = 4;
  parameter int DLY_LSB  = 5;
  parameter int DLY_W    = 2;
  parameter int DIV_LSB  = DLY_LSB + DLY_W;
  parameter int GATE_BIT = DIV_LSB + DIV_W;
  parameter int CNT_W    = $clog2(((1 << DIV_W) - 1) * LOW_MUL + 1);

  typedef struct packed {
    logic             tick;
    logic             run;
    logic [CNT_W-1:0] halfLen;
  } dpStrobe_t;
endpackage

// File: rtl/txclk_ctrl.sv
module txclk_ctrl
  import txclk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  logic        srcTick0,
  input  logic        srcTick1,
  input  logic [1:0]  linkSpeed,
  input  logic        boundary,
  output logic [31:0] rdData,
  output logic [DLY_W-1:0] txDelay,
  output logic        gateBit,
  output dpStrobe_t   strb
);
  logic             selR, gateR;
  logic [DLY_W-1:0] dlyR;
  logic [DIV_W-1:0] divR;
  logic             selS, runS;
  logic [CNT_W-1:0] halfS;
  logic [DIV_W-1:0] divEff;
  logic [CNT_W-1:0] spdMul, halfNext;
  logic             unusedBits;

  assign unusedBits = ^{wrData[31:GATE_BIT+1], wrData[SEL_BIT-1:0]};

  // value 0 of the divider field acts as 1
  assign divEff = (divR == '0) ? DIV_W'(1) : divR;

  always_comb begin
    unique case (linkSpeed)
      2'b00:   spdMul = CNT_W'(LOW_MUL);
      2'b01:   spdMul = CNT_W'(MID_MUL);
      default: spdMul = CNT_W'(1);
    endcase
  end

  assign halfNext = CNT_W'(divEff) * spdMul;

  always_ff @(posedge clk) begin
    if (rst) begin
      selR  <= 1'b0;
      gateR <= 1'b0;
      dlyR  <= '0;
      divR  <= '0;
      selS  <= 1'b0;
      runS  <= 1'b0;
      halfS <= '0;
    end else begin
      if (wrEn) begin
        selR  <= wrData[SEL_BIT];
        gateR <= wrData[GATE_BIT];
        dlyR  <= wrData[DLY_LSB +: DLY_W];
        divR  <= wrData[DIV_LSB +: DIV_W];
      end
      if (boundary) begin
        selS  <= selR;
        runS  <= gateR;
        halfS <= halfNext;
      end
    end
  end

  always_comb begin
    rdData                      = '0;
    rdData[SEL_BIT]             = selR;
    rdData[DLY_LSB +: DLY_W]    = dlyR;
    rdData[DIV_LSB +: DIV_W]    = divR;
    rdData[GATE_BIT]            = gateR;
  end

  assign txDelay      = dlyR;
  assign gateBit      = gateR;
  assign strb.tick    = selS ? srcTick1 : srcTick0;
  assign strb.run     = runS;
  assign strb.halfLen = halfS;

  // R7: latched settings move only at a period boundary
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> ($stable(halfS) && $stable(selS) && $stable(runS)));

  // R9: reset clears the readable register
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (rdData == '0 && txDelay == '0));
endmodule

// File: rtl/txclk_dp.sv
module txclk_dp
  import txclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  dpStrobe_t strb,
  output logic      txClk,
  output logic      boundary
);
  logic [CNT_W-1:0] cnt;
  logic             clkQ;
  logic             lastTick;

  assign lastTick = strb.tick && (cnt == strb.halfLen - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !strb.run) begin
      cnt  <= '0;
      clkQ <= 1'b0;
    end else if (strb.tick) begin
      if (lastTick) begin
        cnt  <= '0;
        clkQ <= ~clkQ;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // end of a full period (falling toggle) or stopped
  assign boundary = !strb.run || (lastTick && clkQ);
  assign txClk    = clkQ;

  // R6: tick count stays inside the current half period
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    strb.run |-> (cnt < strb.halfLen));

  // R1: the output moves only on a tick of the chosen parent
  p_edge_on_tick_r1: assert property (@(posedge clk) disable iff (rst)
    !$stable(clkQ) |-> $past(strb.tick));
endmodule

// File: rtl/txclk_gen.sv
module txclk_gen
  import txclk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        srcTick0,
  input  logic        srcTick1,
  input  logic [1:0]  linkSpeed,
  output logic [1:0]  txDelay,
  output logic        txClk
);
  dpStrobe_t strb;
  logic      boundary;
  logic      gateBit;

  txclk_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .srcTick0 (srcTick0),
    .srcTick1 (srcTick1),
    .linkSpeed(linkSpeed),
    .boundary (boundary),
    .rdData   (rdData),
    .txDelay  (txDelay),
    .gateBit  (gateBit),
    .strb     (strb)
  );

  txclk_dp dp_i (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .txClk   (txClk),
    .boundary(boundary)
  );

  // R4: a closed gate seen at a boundary parks the output low
  p_gate_park_r4: assert property (@(posedge clk) disable iff (rst)
    (!gateBit && boundary) |=> (!txClk && boundary));
endmodule

// File: tb/txclk_gen_tb.sv
module txclk_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {sel, div[2:0], speed[1:0], expected half period in base cycles}
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0, 3'd1, 2'b10, 10'd1},
    {1'b0, 3'd2, 2'b10, 10'd2},
    {1'b0, 3'd0, 2'b10, 10'd1},
    {1'b0, 3'd1, 2'b01, 10'd5},
    {1'b0, 3'd2, 2'b00, 10'd100},
    {1'b1, 3'd1, 2'b10, 10'd3},
    {1'b1, 3'd3, 2'b01, 10'd45},
    {1'b0, 3'd7, 2'b11, 10'd7},
    {1'b1, 3'd2, 2'b00, 10'd300}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        srcTick0 = 1'b1;
  logic        srcTick1 = 1'b0;
  logic [1:0]  linkSpeed = 2'b10;
  logic [1:0]  txDelay;
  logic        txClk;
  int          nRun = 0;
  int          nFail = 0;
  int          cycles = 0;

  txclk_gen dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .srcTick0(srcTick0), .srcTick1(srcTick1), .linkSpeed(linkSpeed),
    .txDelay(txDelay), .txClk(txClk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // parent 1 ticks once every third base cycle
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 3;
      srcTick1 = (ph == 0);
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      summary();
    end
  end

  task automatic chk(string tag, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg(logic gate, logic [2:0] dv, logic sel);
    return (32'(gate) << 10) | (32'(dv) << 7) | (32'(sel) << 4);
  endfunction

  task automatic writeReg(logic [31:0] d);
    @(negedge clk);
    wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic measure(output int hi, output int lo);
    do @(negedge clk); while (txClk);
    do @(negedge clk); while (!txClk);
    hi = 0;
    while (txClk) begin hi++; @(negedge clk); end
    lo = 0;
    while (!txClk) begin lo++; @(negedge clk); end
  endtask

  // rise, then write d after 10 high samples; returns high-phase length
  task automatic midWrite(logic [31:0] d, logic [1:0] spd, output int hi);
    do @(negedge clk); while (txClk);
    do @(negedge clk); while (!txClk);
    hi = 1;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (txClk) hi++; end
    wrData = d; wrEn = 1'b1; linkSpeed = spd;
    @(negedge clk);
    wrEn = 1'b0;
    if (txClk) hi++;
    while (txClk) begin @(negedge clk); if (txClk) hi++; end
  endtask

  initial begin
    int hi, lo, highs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk("R9 rdData", int'(rdData), 0);
    chk("R9 txDelay", int'(txDelay), 0);
    highs = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (txClk) highs++; end
    chk("R9 txClk low", highs, 0);

    // R8: readback mask, R5: delay export
    writeReg(32'hFFFF_FFFF);
    chk("R8 readback", int'(rdData), 32'h0000_07F0);
    chk("R5 delay=3", int'(txDelay), 3);
    writeReg(32'h0000_0040);
    chk("R5 delay=2", int'(txDelay), 2);
    writeReg(32'h0000_0020);
    chk("R5 delay=1", int'(txDelay), 1);
    chk("R8 readback", int'(rdData), 32'h0000_0020);

    // table walk: R1 source, R2 divider, R3 zero field, R6 speed
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      logic [15:0] e = VEC[v];
      tag = e[15] ? "R1" : (e[14:12] == 3'd0) ? "R3" : (e[11:10] != 2'b10) ? "R6" : "R2";
      linkSpeed = e[11:10];
      writeReg(cfg(1'b1, e[14:12], e[15]));
      measure(hi, lo);
      measure(hi, lo);
      chk({tag, " high"}, hi, int'(e[9:0]));
      chk({tag, " low"}, lo, int'(e[9:0]));
    end

    // R7: change mid high phase, old phase completes
    linkSpeed = 2'b00;
    writeReg(cfg(1'b1, 3'd2, 1'b0));
    measure(hi, lo);
    midWrite(cfg(1'b1, 3'd1, 1'b0), 2'b10, hi);
    chk("R7 old high kept", hi, 100);
    measure(hi, lo);
    chk("R7 new high", hi, 1);
    chk("R7 new low", lo, 1);

    // R4: gate closed mid high phase
    linkSpeed = 2'b00;
    writeReg(cfg(1'b1, 3'd2, 1'b0));
    measure(hi, lo);
    midWrite(cfg(1'b0, 3'd2, 1'b0), 2'b00, hi);
    chk("R4 high completes", hi, 100);
    highs = 0;
    for (int k = 0; k < 400; k++) begin @(negedge clk); if (txClk) highs++; end
    chk("R4 stays low", highs, 0);

    summary();
  end
endmodule